// File: doc/BRIEF.md
# Compact RISC Instruction Word Decoder

This block turns the 16-bit instruction words of a small 8-bit microcontroller architecture with 32 general registers into a flat set of control fields. Each input item carries the first instruction word. It also carries the word that follows it, with a flag that says whether that second word is really present. The decoder produces an operation code, two 5-bit register indices, an immediate or address value, an addressing mode, the length of the instruction in words, and two error flags: one for a word that matches no known pattern, one for a two-word instruction whose second word is missing.

The field extraction is purely combinational. It sits behind one output register stage with valid/ready on both sides. An item is taken when `in_valid` and `in_ready` are both high at a rising clock edge. Its decoded result shows up on the outputs with `out_valid` high from the next cycle on. A result is held unchanged for as long as `out_ready` stays low. `in_ready` is high whenever the stage is empty or its result is being taken in the same cycle, so a consumer that never stalls sees one result per clock. The fetch side builds each word little-endian: the byte at the lower address supplies bits 7:0. Execution, register storage and memory are handled elsewhere.

Top module: `idec_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` equals (not `out_valid`) or `out_ready`. An item taken at an edge is presented with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, every output holds its value. Results leave in the order the items were taken, with none lost or repeated.
- R2: Operation codes on `out_op`: NOP 0, MOVI 1, ORI 2, ANDI 3, CMPI 4, SUBI 5, SUBCI 6, ADD 7, ADDC 8, SUB 9, SUBC 10, AND 11, OR 12, XOR 13, MOV 14, CMP 15, CMPC 16, CMPSKIP 17, MUL 18, ZERO 19, TEST 20, SHL 21, ROTL 22, ADDW 23, SUBW 24, FSET 25, FCLR 26, JREL 27, CREL 28, JABS 29, CABS 30, LDDIR 31, STDIR 32, LDIND 33, STIND 34, NOT 35, NEG 36, NSWAP 37, INC 38, SHRA 39, SHR 40, ROTR 41, DEC 42, RET 43, RETI 44. Addressing mode codes: 0 none, 1 post-increment, 2 pre-decrement, 3 displacement. Any field an operation does not use reads 0. The word 0x0000 is NOP with both flags clear and length 1.
- R3: The register-immediate group uses the prefix in bits 15:12: 1110 MOVI, 0110 ORI, 0111 ANDI, 0011 CMPI, 0101 SUBI, 0100 SUBCI. For these, `out_rd` = 16 + bits 7:4 and `out_imm` = {bits 11:8, bits 3:0}.
- R4: The two-register group uses the prefix in bits 15:10: 000011 ADD, 000111 ADDC, 000110 SUB, 000010 SUBC, 001000 AND, 001010 OR, 001001 XOR, 001011 MOV, 000101 CMP, 000001 CMPC, 000100 CMPSKIP, 100111 MUL. For these, `out_rd` = bits 8:4 and `out_rr` = {bit 9, bits 3:0}.
- R5: When both register fields are equal, XOR decodes as ZERO, AND as TEST, ADD as SHL and ADDC as ROTL. Both register outputs still carry the register number.
- R6: The words 1001_0110_KKdd_KKKK (ADDW) and 1001_0111_KKdd_KKKK (SUBW) give `out_rd` = 24 + 2·dd and `out_imm` = {bits 7:6, bits 3:0}.
- R7: 1001_0100_0sss_1000 is FSET and 1001_0100_1sss_1000 is FCLR, with `out_imm` = sss.
- R8: The prefix 1100 is JREL and 1101 is CREL. `out_imm` is bits 11:0 sign-extended to 22 bits.
- R9: The long forms take two words and report `out_len`=2: JABS (1001_010k_kkkk_110k), CABS (1001_010k_kkkk_111k), LDDIR (1001_000d_dddd_0000) and STDIR (1001_001d_dddd_0000). JABS and CABS give `out_imm` = {bits 8:4, bit 0, second word}. LDDIR and STDIR give `out_rd` = bits 8:4 and `out_imm` = second word. All other instructions report `out_len`=1.
- R10: A long form whose second word is not available (`in_word1_ok`=0) reports `out_trunc`=1, op NOP, `out_len`=2, `out_undef`=0, and every other field 0.
- R11: 1001_00sd_dddd_ppmm is an indirect transfer, LDIND when s=0 and STIND when s=1. The data register is on `out_rd` = bits 8:4. The pointer is on `out_rr`: pp=11 gives 26, 10 gives 28, 00 gives 30. mm=01 is mode 1 and mm=10 is mode 2. mm=00 is mode 0, and it is defined only for pp=11.
- R12: The displacement form 10q0_qqsd_dddd_yqqq is LDIND (s=0) or STIND (s=1) with mode 3. `out_imm` = {bit 13, bits 11:10, bits 2:0}. `out_rr` is 28 when y=1 and 30 when y=0. `out_rd` = bits 8:4. An offset of 0 still reports mode 3.
- R13: 1001_010d_dddd_nnnn with nnnn = 0000 NOT, 0001 NEG, 0010 NSWAP, 0011 INC, 0101 SHRA, 0110 SHR, 0111 ROTR or 1010 DEC gives `out_rd` = bits 8:4. 0x9508 is RET and 0x9518 is RETI.
- R14: Any word that matches none of the patterns above reports `out_undef`=1, op NOP, length 1, and every other field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Stage can take an item this cycle |
| in_word0 | input | 16 | First instruction word |
| in_word1 | input | 16 | Following word |
| in_word1_ok | input | 1 | Following word is available |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_op | output | 6 | Operation code |
| out_rd | output | 5 | Destination or data register |
| out_rr | output | 5 | Source or pointer register |
| out_imm | output | 22 | Immediate, offset or address |
| out_amode | output | 2 | Addressing mode |
| out_len | output | 2 | Length in words (1 or 2) |
| out_undef | output | 1 | No pattern matched |
| out_trunc | output | 1 | Second word missing |

## Verification
The stage can take a new instruction word and hand over its held result in the same clock. This happens whenever `out_valid` and `out_ready` are both high while `in_valid` is high. The bench provokes it with back-to-back items against a consumer that is always ready. It then throttles `out_ready` in a repeating pattern, so that acceptance, hand-over and stalls interleave. The scoreboard judges this: every result must come out exactly once and in order, with fields equal to the values computed from the requirements, and results that are held across stall cycles must stay unchanged.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 5;
  localparam int HI_W   = 6;
  localparam int IMM_W  = WORD_W + HI_W;
  localparam int OP_W   = 6;
  localparam int AM_W   = 2;
  localparam int LEN_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP, OP_MOVI, OP_ORI, OP_ANDI, OP_CMPI, OP_SUBI, OP_SUBCI,
    OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_AND, OP_OR, OP_XOR, OP_MOV,
    OP_CMP, OP_CMPC, OP_CMPSKIP, OP_MUL, OP_ZERO, OP_TEST, OP_SHL, OP_ROTL,
    OP_ADDW, OP_SUBW, OP_FSET, OP_FCLR, OP_JREL, OP_CREL, OP_JABS, OP_CABS,
    OP_LDDIR, OP_STDIR, OP_LDIND, OP_STIND, OP_NOT, OP_NEG, OP_NSWAP,
    OP_INC, OP_SHRA, OP_SHR, OP_ROTR, OP_DEC, OP_RET, OP_RETI
  } op_e;

  typedef enum logic [AM_W-1:0] {
    AM_NONE = 2'd0, AM_POSTINC = 2'd1, AM_PREDEC = 2'd2, AM_DISP = 2'd3
  } am_e;
endpackage

// File: rtl/idec_core.sv
module idec_core
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic              w1_ok,
  output op_e               op,
  output logic [REG_W-1:0]  rd,
  output logic [REG_W-1:0]  rr,
  output logic [IMM_W-1:0]  imm,
  output am_e               am,
  output logic [LEN_W-1:0]  len,
  output logic              undef,
  output logic              trunc
);
  logic [REG_W-1:0] d5, r5;
  logic [7:0]       k8;
  logic             fmt_rr, fmt_ri, is_long, bad;

  assign d5 = w0[8:4];
  assign r5 = {w0[9], w0[3:0]};
  assign k8 = {w0[11:8], w0[3:0]};

  always_comb begin
    op = OP_NOP; rd = '0; rr = '0; imm = '0; am = AM_NONE;
    len = LEN_W'(1); undef = 1'b0; trunc = 1'b0;
    fmt_rr = 1'b0; fmt_ri = 1'b0; is_long = 1'b0; bad = 1'b0;
    casez (w0)
      16'h0000:              op = OP_NOP;
      16'b0000_01??_????_????: begin op = OP_CMPC;    fmt_rr = 1'b1; end
      16'b0000_10??_????_????: begin op = OP_SUBC;    fmt_rr = 1'b1; end
      16'b0000_11??_????_????: begin op = (d5 == r5) ? OP_SHL  : OP_ADD;  fmt_rr = 1'b1; end
      16'b0001_00??_????_????: begin op = OP_CMPSKIP; fmt_rr = 1'b1; end
      16'b0001_01??_????_????: begin op = OP_CMP;     fmt_rr = 1'b1; end
      16'b0001_10??_????_????: begin op = OP_SUB;     fmt_rr = 1'b1; end
      16'b0001_11??_????_????: begin op = (d5 == r5) ? OP_ROTL : OP_ADDC; fmt_rr = 1'b1; end
      16'b0010_00??_????_????: begin op = (d5 == r5) ? OP_TEST : OP_AND;  fmt_rr = 1'b1; end
      16'b0010_01??_????_????: begin op = (d5 == r5) ? OP_ZERO : OP_XOR;  fmt_rr = 1'b1; end
      16'b0010_10??_????_????: begin op = OP_OR;      fmt_rr = 1'b1; end
      16'b0010_11??_????_????: begin op = OP_MOV;     fmt_rr = 1'b1; end
      16'b1001_11??_????_????: begin op = OP_MUL;     fmt_rr = 1'b1; end
      16'b0011_????_????_????: begin op = OP_CMPI;    fmt_ri = 1'b1; end
      16'b0100_????_????_????: begin op = OP_SUBCI;   fmt_ri = 1'b1; end
      16'b0101_????_????_????: begin op = OP_SUBI;    fmt_ri = 1'b1; end
      16'b0110_????_????_????: begin op = OP_ORI;     fmt_ri = 1'b1; end
      16'b0111_????_????_????: begin op = OP_ANDI;    fmt_ri = 1'b1; end
      16'b1110_????_????_????: begin op = OP_MOVI;    fmt_ri = 1'b1; end
      16'b1100_????_????_????: begin op = OP_JREL; imm = IMM_W'($signed(w0[11:0])); end
      16'b1101_????_????_????: begin op = OP_CREL; imm = IMM_W'($signed(w0[11:0])); end
      16'b10?0_????_????_????: begin
        op  = w0[9] ? OP_STIND : OP_LDIND;
        rd  = d5;
        rr  = w0[3] ? REG_W'(28) : REG_W'(30);
        am  = AM_DISP;
        imm = IMM_W'({w0[13], w0[11:10], w0[2:0]});
      end
      16'b1001_0110_????_????, 16'b1001_0111_????_????: begin
        op  = w0[8] ? OP_SUBW : OP_ADDW;
        rd  = {2'b11, w0[5:4], 1'b0};
        imm = IMM_W'({w0[7:6], w0[3:0]});
      end
      16'b1001_00??_????_????: begin
        rd = d5;
        if (w0[3:0] == 4'b0000) begin
          op = w0[9] ? OP_STDIR : OP_LDDIR;
          is_long = 1'b1;
          imm = IMM_W'(w1);
        end else if (w0[3:2] == 2'b01 || w0[1:0] == 2'b11 ||
                     (w0[1:0] == 2'b00 && w0[3:2] != 2'b11)) begin
          bad = 1'b1;
        end else begin
          op = w0[9] ? OP_STIND : OP_LDIND;
          case (w0[3:2])
            2'b11:   rr = REG_W'(26);
            2'b10:   rr = REG_W'(28);
            default: rr = REG_W'(30);
          endcase
          case (w0[1:0])
            2'b01:   am = AM_POSTINC;
            2'b10:   am = AM_PREDEC;
            default: am = AM_NONE;
          endcase
        end
      end
      16'b1001_010?_????_????: begin
        rd = d5;
        casez (w0[3:0])
          4'b0000: op = OP_NOT;
          4'b0001: op = OP_NEG;
          4'b0010: op = OP_NSWAP;
          4'b0011: op = OP_INC;
          4'b0101: op = OP_SHRA;
          4'b0110: op = OP_SHR;
          4'b0111: op = OP_ROTR;
          4'b1010: op = OP_DEC;
          4'b11??: begin
            op = w0[1] ? OP_CABS : OP_JABS;
            rd = '0;
            is_long = 1'b1;
            imm = {w0[8:4], w0[0], w1};
          end
          4'b1000: begin
            rd = '0;
            if (!w0[8]) begin
              op  = w0[7] ? OP_FCLR : OP_FSET;
              imm = IMM_W'(w0[6:4]);
            end else if (w0 == 16'h9508) op = OP_RET;
            else if (w0 == 16'h9518) op = OP_RETI;
            else bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase

    if (fmt_rr) begin rd = d5; rr = r5; end
    if (fmt_ri) begin rd = {1'b1, w0[7:4]}; imm = IMM_W'(k8); end
    if (is_long) len = LEN_W'(2);
    if (bad || (is_long && !w1_ok)) begin
      op = OP_NOP; rd = '0; rr = '0; imm = '0; am = AM_NONE;
      undef = bad;
      trunc = !bad;
    end
  end
endmodule

// File: rtl/idec_hold.sv
module idec_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full;
  logic [W-1:0] held;

  assign in_ready  = !full || out_ready;
  assign out_valid = full;
  assign out_data  = held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (in_ready) begin
      full <= in_valid;
      if (in_valid) held <= in_data;
    end
  end
endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word0,
  input  logic [WORD_W-1:0] in_word1,
  input  logic              in_word1_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   out_op,
  output logic [REG_W-1:0]  out_rd,
  output logic [REG_W-1:0]  out_rr,
  output logic [IMM_W-1:0]  out_imm,
  output logic [AM_W-1:0]   out_amode,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_undef,
  output logic              out_trunc
);
  localparam int PW = OP_W + 2*REG_W + IMM_W + AM_W + LEN_W + 2;

  op_e              c_op;
  am_e              c_am;
  logic [REG_W-1:0] c_rd, c_rr;
  logic [IMM_W-1:0] c_imm;
  logic [LEN_W-1:0] c_len;
  logic             c_undef, c_trunc;
  logic [PW-1:0]    c_pack, q_pack;

  idec_core u_core (
    .w0(in_word0), .w1(in_word1), .w1_ok(in_word1_ok),
    .op(c_op), .rd(c_rd), .rr(c_rr), .imm(c_imm), .am(c_am),
    .len(c_len), .undef(c_undef), .trunc(c_trunc)
  );

  assign c_pack = {c_op, c_rd, c_rr, c_imm, c_am, c_len, c_undef, c_trunc};

  idec_hold #(.W(PW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(c_pack),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(q_pack)
  );

  assign {out_op, out_rd, out_rr, out_imm, out_amode, out_len, out_undef, out_trunc} = q_pack;
endmodule

// File: rtl/idec_chk.sv
module idec_chk
  import idec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OP_W-1:0]   out_op,
  input logic [REG_W-1:0]  out_rd,
  input logic [REG_W-1:0]  out_rr,
  input logic [IMM_W-1:0]  out_imm,
  input logic [AM_W-1:0]   out_amode,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_undef,
  input logic              out_trunc
);
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_op, out_rd, out_rr, out_imm, out_amode, out_len, out_undef, out_trunc}));

  a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r9_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == 2'd1 || out_len == 2'd2));

  a_r10_trunc_form: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trunc |-> out_len == 2'd2 && !out_undef && out_op == OP_NOP && out_imm == '0);

  a_r14_undef_form: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_op == OP_NOP && out_len == 2'd1 && out_rd == '0 && out_rr == '0);

  a_r3_upper_reg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op >= OP_MOVI && out_op <= OP_SUBCI |-> out_rd[REG_W-1]);

  a_r6_pair_reg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_op == OP_ADDW || out_op == OP_SUBW) |-> out_rd[4:3] == 2'b11 && !out_rd[0]);

  a_r12_disp_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_amode == AM_DISP |-> (out_rr == 5'd28 || out_rr == 5'd30));
endmodule

bind idec_top idec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
  .out_rd(out_rd), .out_rr(out_rr), .out_imm(out_imm), .out_amode(out_amode),
  .out_len(out_len), .out_undef(out_undef), .out_trunc(out_trunc)
);

// File: tb/test_idec_top.sv
module test_idec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word0 = '0;
  logic [15:0] in_word1 = '0;
  logic        in_word1_ok = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [5:0]  out_op;
  logic [4:0]  out_rd, out_rr;
  logic [21:0] out_imm;
  logic [1:0]  out_amode, out_len;
  logic        out_undef, out_trunc;

  typedef struct {
    string       tag;
    logic [15:0] w0;
    logic [5:0]  op;
    logic [4:0]  rd, rr;
    logic [21:0] imm;
    logic [1:0]  am, len;
    logic        und, tr;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   throttle = 1'b0;
  int   rcnt = 0;

  always #10 clk = ~clk;

  idec_top i_idec_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word0(in_word0), .in_word1(in_word1), .in_word1_ok(in_word1_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_rd(out_rd), .out_rr(out_rr), .out_imm(out_imm), .out_amode(out_amode),
    .out_len(out_len), .out_undef(out_undef), .out_trunc(out_trunc)
  );

  task automatic send(string tag, logic [15:0] w0, logic [15:0] w1, logic ok,
                      logic [5:0] op, logic [4:0] rd, logic [4:0] rr,
                      logic [21:0] imm, logic [1:0] am, logic [1:0] len,
                      logic und, logic tr);
    exp_t e;
    e.tag = tag; e.w0 = w0; e.op = op; e.rd = rd; e.rr = rr; e.imm = imm;
    e.am = am; e.len = len; e.und = und; e.tr = tr;
    @(negedge clk);
    in_valid = 1'b1; in_word0 = w0; in_word1 = w1; in_word1_ok = ok;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    q.push_back(e);
    @(posedge clk);
  endtask

  // consumer ready pattern
  initial forever begin
    @(negedge clk);
    rcnt++;
    out_ready = !throttle || (rcnt % 3 != 1);
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    #5;
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected result op=%0d, expected none", out_op);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_op !== e.op || out_rd !== e.rd || out_rr !== e.rr || out_imm !== e.imm ||
            out_amode !== e.am || out_len !== e.len || out_undef !== e.und || out_trunc !== e.tr) begin
          fails++;
          $display("FAIL %s w0=%h actual op=%0d rd=%0d rr=%0d imm=%h am=%0d len=%0d u=%b t=%b expected op=%0d rd=%0d rr=%0d imm=%h am=%0d len=%0d u=%b t=%b",
                   e.tag, e.w0, out_op, out_rd, out_rr, out_imm, out_amode, out_len, out_undef, out_trunc,
                   e.op, e.rd, e.rr, e.imm, e.am, e.len, e.und, e.tr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic batch();
    send("R3",  16'hE5A3, 16'h0, 1'b0,  6'd1, 5'd26, 5'd0, 22'h53, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R3",  16'h3000, 16'h0, 1'b0,  6'd4, 5'd16, 5'd0, 22'h0,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R4",  16'h0C12, 16'h0, 1'b0,  6'd7, 5'd1,  5'd2, 22'h0,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R4",  16'h2034, 16'h0, 1'b0,  6'd11, 5'd3, 5'd4, 22'h0,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R4",  16'h9C12, 16'h0, 1'b0,  6'd18, 5'd1, 5'd2, 22'h0,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R5",  16'h0C55, 16'h0, 1'b0,  6'd21, 5'd5, 5'd5, 22'h0,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R5",  16'h2711, 16'h0, 1'b0,  6'd19, 5'd17, 5'd17, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R5",  16'h1FFF, 16'h0, 1'b0,  6'd22, 5'd31, 5'd31, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R5",  16'h2000, 16'h0, 1'b0,  6'd20, 5'd0, 5'd0, 22'h0,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R6",  16'h97FF, 16'h0, 1'b0,  6'd24, 5'd30, 5'd0, 22'd63, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R6",  16'h9681, 16'h0, 1'b0,  6'd23, 5'd24, 5'd0, 22'h21, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R7",  16'h9458, 16'h0, 1'b0,  6'd25, 5'd0, 5'd0, 22'd5,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R7",  16'h94A8, 16'h0, 1'b0,  6'd26, 5'd0, 5'd0, 22'd2,  2'd0, 2'd1, 1'b0, 1'b0);
    send("R8",  16'hCFFF, 16'h0, 1'b0,  6'd27, 5'd0, 5'd0, 22'h3FFFFF, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R8",  16'hD7FF, 16'h0, 1'b0,  6'd28, 5'd0, 5'd0, 22'h7FF, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R9",  16'h940C, 16'h1234, 1'b1, 6'd29, 5'd0, 5'd0, 22'h1234, 2'd0, 2'd2, 1'b0, 1'b0);
    send("R9",  16'h95FF, 16'hABCD, 1'b1, 6'd30, 5'd0, 5'd0, 22'h3FABCD, 2'd0, 2'd2, 1'b0, 1'b0);
    send("R9",  16'h9140, 16'h0100, 1'b1, 6'd31, 5'd20, 5'd0, 22'h100, 2'd0, 2'd2, 1'b0, 1'b0);
    send("R9",  16'h9230, 16'hFFFF, 1'b1, 6'd32, 5'd3, 5'd0, 22'hFFFF, 2'd0, 2'd2, 1'b0, 1'b0);
    send("R10", 16'h940C, 16'h1234, 1'b0, 6'd0, 5'd0, 5'd0, 22'h0, 2'd0, 2'd2, 1'b0, 1'b1);
    send("R10", 16'h9230, 16'hFFFF, 1'b0, 6'd0, 5'd0, 5'd0, 22'h0, 2'd0, 2'd2, 1'b0, 1'b1);
    send("R11", 16'h905D, 16'h0, 1'b0,  6'd33, 5'd5, 5'd26, 22'h0, 2'd1, 2'd1, 1'b0, 1'b0);
    send("R11", 16'h929A, 16'h0, 1'b0,  6'd34, 5'd9, 5'd28, 22'h0, 2'd2, 2'd1, 1'b0, 1'b0);
    send("R11", 16'h900C, 16'h0, 1'b0,  6'd33, 5'd0, 5'd26, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R11", 16'h93F1, 16'h0, 1'b0,  6'd34, 5'd31, 5'd30, 22'h0, 2'd1, 2'd1, 1'b0, 1'b0);
    send("R12", 16'hAC7F, 16'h0, 1'b0,  6'd33, 5'd7, 5'd28, 22'd63, 2'd3, 2'd1, 1'b0, 1'b0);
    send("R12", 16'h8210, 16'h0, 1'b0,  6'd34, 5'd1, 5'd30, 22'd0, 2'd3, 2'd1, 1'b0, 1'b0);
    send("R13", 16'h94CA, 16'h0, 1'b0,  6'd42, 5'd12, 5'd0, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R13", 16'h9502, 16'h0, 1'b0,  6'd37, 5'd16, 5'd0, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R13", 16'h9508, 16'h0, 1'b0,  6'd43, 5'd0, 5'd0, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R13", 16'h9518, 16'h0, 1'b0,  6'd44, 5'd0, 5'd0, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R2",  16'h0000, 16'h0, 1'b0,  6'd0, 5'd0, 5'd0, 22'h0, 2'd0, 2'd1, 1'b0, 1'b0);
    send("R14", 16'hFFFF, 16'h0, 1'b0,  6'd0, 5'd0, 5'd0, 22'h0, 2'd0, 2'd1, 1'b1, 1'b0);
    send("R14", 16'h0100, 16'h0, 1'b0,  6'd0, 5'd0, 5'd0, 22'h0, 2'd0, 2'd1, 1'b1, 1'b0);
    send("R14", 16'h9008, 16'h0, 1'b0,  6'd0, 5'd0, 5'd0, 22'h0, 2'd0, 2'd1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    // back-to-back with a consumer that never stalls (R1 same-cycle take and hand-over)
    batch();
    // throttled consumer: stalls interleave with takes
    throttle = 1'b1;
    batch();
    @(negedge clk);
    in_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule